// File: doc/BRIEF.md
# Legacy virtio register interface

This block is the port-mapped register front end of a legacy virtio PCI function that serves several queues. A host-side access port presents one read or write per cycle with a byte, word or dword size. Behind it sit the feature words, a queue selector, one page-number register and one fixed ring size per queue, the device status byte and the interrupt status byte. Offsets from the device-config base upward go straight through to a device-specific config window. Queue processing itself lives elsewhere. This block only tells the queue engine which queue was kicked and where that queue's rings are.

A small lifecycle state machine follows the status byte. It has five states. `ST_IDLE` holds while the status is zero. `ST_SETUP` holds while the status is nonzero and the driver-ok bit is clear. `ST_READY` lasts one cycle and is the ready pulse. `ST_LIVE` holds while the driver is running. `ST_RESET` lasts one cycle and is the device-reset pulse.

The transitions are as follows:
- A status write of zero, or a page-number write of zero, goes to `ST_RESET`.
- A status write that newly sets the driver-ok bit goes to `ST_READY`.
- A status write that keeps the driver-ok bit set goes to `ST_LIVE`.
- Any other nonzero status write goes to `ST_SETUP`.
- With no such write, `ST_READY` moves on to `ST_LIVE` and `ST_RESET` moves on to `ST_IDLE`.
- All other states hold.

Top module: `vio_port_regfile`

Offset map: host features 0x00 (dword), guest features 0x04 (dword), page number 0x08 (dword), queue size 0x0C (word), selector 0x0E (word), notify 0x10 (word), status 0x12 (byte), interrupt status 0x13 (byte), device config from 0x14 upward. Writes keep only the width of the register they hit.

## Requirements
- R1: A read of offset 0x00 returns the host feature parameter ORed with the notify-on-empty bit (bit 24) and the bad-feature bit (bit 30). With default parameters this is 0x4100_0021.
- R2: A write to offset 0x04 is handled in one of three ways, and the stored value appears on `guest_feat_o` and on reads of 0x04.
  - If the value has no bit outside the advertised set (host features plus bit 24), it is stored as written.
  - Otherwise, if bit 30 is set, the minimal feature parameter is stored (default 0x20).
  - Otherwise the value ANDed with the advertised set is stored.
- R3: A write to 0x0E keeps data bits [15:0]. The selector changes only when that value is below the queue count, and otherwise is left unchanged. Reads of 0x08 and 0x0C follow the selected queue. Queue i reports size 2^(QSIZE_LOG2-i), which is 256, 128 and 64 by default.
- R4: A write to 0x08 stores the dword for the selected queue. That queue's ring addresses are derived from it:
  - descriptor base = page << 12
  - avail = descriptor base + 16*size
  - used = (avail + 4 + 2*size) rounded up to a multiple of 4096
- R5: A write to 0x10 forwards a notify for queue q = data[15:0] only when q is below the queue count and queue q has a nonzero page. In that case bit q of `notify_o` is high for exactly the next cycle, together with that queue's three ring addresses. Otherwise `notify_o` stays zero.
- R6: Cause bits on `irq_cause_i` are ORed into the interrupt status, and `irq_o` is high from the next cycle.
- R7: A read of 0x13 returns the interrupt status and clears it. `irq_o` falls in the next cycle, unless a cause was raised in the same cycle as the read. That cause is kept as the new status and `irq_o` stays high.
- R8: The first status write that sets bit 2 (driver ok) while the stored status has bit 2 clear gives a one-cycle `ready_o` pulse in the next cycle and sets `busmaster_o`. `busmaster_o` stays set until the hard reset. A later write that keeps bit 2 set gives no pulse.
- R9: A status write of zero, or a page-number write of zero, gives a one-cycle `dev_reset_o` pulse in the next cycle. The same write clears the guest features, the selector, the status, the interrupt status with `irq_o`, and every queue's page. `busmaster_o` is not affected.
- R10: An access at offset 0x14 or above is passed combinationally to the config window as `cfg_req_o`, with the offset minus 0x14, the size, the write flag and the write data. A read returns `cfg_rdata_i` as sampled in the request cycle.
- R11: Read data and `rvalid_o` appear in the cycle after the read request. A read of any other offset below 0x14, including the notify offset 0x10 and 0x11, returns 0xFFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset within the port range |
| size_i | input | 2 | 0 byte, 1 word, 2 dword |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| irq_cause_i | input | ISR_W | Interrupt cause bits to raise (bit 0 = queue) |
| irq_o | output | 1 | Interrupt line |
| guest_feat_o | output | 32 | Negotiated guest features |
| dev_reset_o | output | 1 | Device reset pulse |
| ready_o | output | 1 | Driver-ready pulse |
| busmaster_o | output | 1 | Bus-master enable |
| notify_o | output | NQ | One-hot queue notify strobe |
| notify_desc_o | output | 64 | Descriptor table address of notified queue |
| notify_avail_o | output | 64 | Avail ring address of notified queue |
| notify_used_o | output | 64 | Used ring address of notified queue |
| cfg_req_o | output | 1 | Config window access |
| cfg_we_o | output | 1 | Config window write |
| cfg_addr_o | output | ADDR_W | Offset inside the config window |
| cfg_size_o | output | 2 | Config access size |
| cfg_wdata_o | output | 32 | Config write data |
| cfg_rdata_i | input | 32 | Config read data |

## Verification
The interrupt status register has two functions that can fall in the same cycle: the clear-on-read and the raising of a new cause. The bench provokes the collision by driving an interrupt-status read and a cause pulse on the same clock edge. It judges the result in two places. The read data must show only the earlier causes, and `irq_o` must stay high afterwards. A second read must then return exactly the cause that arrived during the first one. A soft reset issued while an interrupt is pending is checked in the same way: `irq_o` must drop, and no status bit may survive.

// File: rtl/vio_pkg.sv
package vio_pkg;

    localparam int VIO_AW = 8;

    localparam logic [VIO_AW-1:0] OFF_HOST_FEAT  = 8'h00;
    localparam logic [VIO_AW-1:0] OFF_GUEST_FEAT = 8'h04;
    localparam logic [VIO_AW-1:0] OFF_PAGE       = 8'h08;
    localparam logic [VIO_AW-1:0] OFF_QSIZE      = 8'h0C;
    localparam logic [VIO_AW-1:0] OFF_QSEL       = 8'h0E;
    localparam logic [VIO_AW-1:0] OFF_NOTIFY     = 8'h10;
    localparam logic [VIO_AW-1:0] OFF_STATUS     = 8'h12;
    localparam logic [VIO_AW-1:0] OFF_ISR        = 8'h13;
    localparam logic [VIO_AW-1:0] OFF_CFG_BASE   = 8'h14;

    localparam int STATUS_DRV_OK_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READY,
        ST_LIVE,
        ST_RESET
    } dev_state_t;

endpackage

// File: rtl/vio_feat_neg.sv
module vio_feat_neg #(
    parameter logic [31:0] HOST_FEAT  = 32'h0000_0021,
    parameter logic [31:0] MIN_FEAT   = 32'h0000_0020,
    parameter int          NOTIFY_BIT = 24,
    parameter int          BAD_BIT    = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        clr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] host_rd_o,
    output logic [31:0] guest_o
);
    localparam logic [31:0] ADVERTISED = HOST_FEAT | (32'd1 << NOTIFY_BIT);
    localparam logic [31:0] BAD_MASK   = 32'd1 << BAD_BIT;

    logic [31:0] guest_q;
    logic [31:0] accepted;

    always_comb begin
        if ((wdata_i & ~ADVERTISED) == 32'd0)
            accepted = wdata_i;
        else if ((wdata_i & BAD_MASK) != 32'd0)
            accepted = MIN_FEAT;
        else
            accepted = wdata_i & ADVERTISED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            guest_q <= '0;
        else if (clr_i)
            guest_q <= '0;
        else if (wr_i)
            guest_q <= accepted;
    end

    assign host_rd_o = ADVERTISED | BAD_MASK;
    assign guest_o   = guest_q;

    // R2: whatever is stored never carries the bad-feature bit
    a_r2_no_bad_bit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && !clr_i && ((MIN_FEAT & BAD_MASK) == 32'd0) |=> ((guest_o & BAD_MASK) == 32'd0));
endmodule

// File: rtl/vio_queue_slot.sv
module vio_queue_slot #(
    parameter int QSIZE      = 256,
    parameter int PAGE_SHIFT = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic        clr_i,
    input  logic [31:0] page_i,
    output logic [31:0] page_o,
    output logic [15:0] size_o,
    output logic        active_o,
    output logic [63:0] desc_o,
    output logic [63:0] avail_o,
    output logic [63:0] used_o
);
    localparam logic [63:0] DESC_BYTES  = 64'(16 * QSIZE);
    localparam logic [63:0] AVAIL_BYTES = 64'(4 + 2 * QSIZE);
    localparam logic [63:0] PAGE_BYTES  = 64'd1 << PAGE_SHIFT;
    localparam logic [63:0] PAGE_MASK   = ~(PAGE_BYTES - 64'd1);

    logic [31:0] page_q;
    logic [63:0] used_raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            page_q <= '0;
        else if (clr_i)
            page_q <= '0;
        else if (wr_i)
            page_q <= page_i;
    end

    assign desc_o   = {32'd0, page_q} << PAGE_SHIFT;
    assign avail_o  = desc_o + DESC_BYTES;
    assign used_raw = avail_o + AVAIL_BYTES + PAGE_BYTES - 64'd1;
    assign used_o   = used_raw & PAGE_MASK;
    assign page_o   = page_q;
    assign size_o   = 16'(QSIZE);
    assign active_o = (page_q != 32'd0);

    // R4: the used ring always starts on a page boundary past the avail ring
    a_r4_used_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> ((used_o & ~PAGE_MASK) == 64'd0) && (used_o > avail_o));
endmodule

// File: rtl/vio_isr.sv
module vio_isr #(
    parameter int ISR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ISR_W-1:0] cause_i,
    input  logic             rd_i,
    input  logic             clr_i,
    output logic [ISR_W-1:0] isr_o,
    output logic             irq_o
);
    logic [ISR_W-1:0] isr_q;
    logic             irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
            irq_q <= 1'b0;
        end else if (clr_i) begin
            isr_q <= '0;
            irq_q <= 1'b0;
        end else if (rd_i) begin
            isr_q <= cause_i;
            irq_q <= |cause_i;
        end else begin
            isr_q <= isr_q | cause_i;
            if (|cause_i)
                irq_q <= 1'b1;
        end
    end

    assign isr_o = isr_q;
    assign irq_o = irq_q;

    // R6: a raised cause lands in the status and lifts the line
    a_r6_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !rd_i && (cause_i != '0)) |=> (irq_o && ((isr_o & $past(cause_i)) == $past(cause_i))));

    // R7: after a read only the causes of the read cycle remain
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !clr_i) |=> (isr_o == $past(cause_i)));

    // R9: soft reset drops the line
    a_r9_clr_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!irq_o && (isr_o == '0)));
endmodule

// File: rtl/vio_port_regfile.sv
module vio_port_regfile
    import vio_pkg::*;
#(
    parameter int          NQ          = 3,
    parameter int          QSIZE_LOG2  = 8,
    parameter int          PAGE_SHIFT  = 12,
    parameter int          ISR_W       = 8,
    parameter int          ADDR_W      = VIO_AW,
    parameter logic [31:0] HOST_FEAT   = 32'h0000_0021,
    parameter logic [31:0] MIN_FEAT    = 32'h0000_0020,
    parameter int          NOTIFY_BIT  = 24,
    parameter int          BAD_BIT     = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [31:0]       wdata_i,
    output logic              rvalid_o,
    output logic [31:0]       rdata_o,
    input  logic [ISR_W-1:0]  irq_cause_i,
    output logic              irq_o,
    output logic [31:0]       guest_feat_o,
    output logic              dev_reset_o,
    output logic              ready_o,
    output logic              busmaster_o,
    output logic [NQ-1:0]     notify_o,
    output logic [63:0]       notify_desc_o,
    output logic [63:0]       notify_avail_o,
    output logic [63:0]       notify_used_o,
    output logic              cfg_req_o,
    output logic              cfg_we_o,
    output logic [ADDR_W-1:0] cfg_addr_o,
    output logic [1:0]        cfg_size_o,
    output logic [31:0]       cfg_wdata_o,
    input  logic [31:0]       cfg_rdata_i
);
    localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
    localparam logic [15:0] NQ16 = 16'(NQ);
    localparam logic [ADDR_W-1:0] A_HOST  = ADDR_W'(OFF_HOST_FEAT);
    localparam logic [ADDR_W-1:0] A_GUEST = ADDR_W'(OFF_GUEST_FEAT);
    localparam logic [ADDR_W-1:0] A_PAGE  = ADDR_W'(OFF_PAGE);
    localparam logic [ADDR_W-1:0] A_QSIZE = ADDR_W'(OFF_QSIZE);
    localparam logic [ADDR_W-1:0] A_QSEL  = ADDR_W'(OFF_QSEL);
    localparam logic [ADDR_W-1:0] A_NOTIF = ADDR_W'(OFF_NOTIFY);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_ISR   = ADDR_W'(OFF_ISR);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(OFF_CFG_BASE);

    // access decode
    logic rd, wr, in_cfg;
    logic wr_guest, wr_page, wr_sel, wr_notify, wr_status, rd_isr;
    logic soft_rst;

    assign rd        = req_i && !we_i;
    assign wr        = req_i && we_i;
    assign in_cfg    = (addr_i >= A_CFG);
    assign wr_guest  = wr && (addr_i == A_GUEST);
    assign wr_page   = wr && (addr_i == A_PAGE);
    assign wr_sel    = wr && (addr_i == A_QSEL);
    assign wr_notify = wr && (addr_i == A_NOTIF);
    assign wr_status = wr && (addr_i == A_STAT);
    assign rd_isr    = rd && (addr_i == A_ISR);
    assign soft_rst  = (wr_status && (wdata_i[7:0] == 8'd0)) ||
                       (wr_page && (wdata_i == 32'd0));

    // config window pass-through
    assign cfg_req_o   = req_i && in_cfg;
    assign cfg_we_o    = we_i;
    assign cfg_addr_o  = addr_i - A_CFG;
    assign cfg_size_o  = size_i;
    assign cfg_wdata_o = wdata_i;

    // selector and status
    logic [15:0] sel_q;
    logic [7:0]  status_q;
    logic [QW-1:0] sel_idx;

    assign sel_idx = sel_q[QW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            status_q <= '0;
        end else if (soft_rst) begin
            sel_q    <= '0;
            status_q <= '0;
        end else begin
            if (wr_sel && (wdata_i[15:0] < NQ16))
                sel_q <= wdata_i[15:0];
            if (wr_status)
                status_q <= wdata_i[7:0];
        end
    end

    // feature negotiation
    logic [31:0] host_rd;

    vio_feat_neg #(
        .HOST_FEAT (HOST_FEAT),
        .MIN_FEAT  (MIN_FEAT),
        .NOTIFY_BIT(NOTIFY_BIT),
        .BAD_BIT   (BAD_BIT)
    ) u_feat (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_guest),
        .clr_i    (soft_rst),
        .wdata_i  (wdata_i),
        .host_rd_o(host_rd),
        .guest_o  (guest_feat_o)
    );

    // interrupt status
    logic [ISR_W-1:0] isr_val;

    vio_isr #(.ISR_W(ISR_W)) u_isr (
        .clk    (clk),
        .rst_n  (rst_n),
        .cause_i(irq_cause_i),
        .rd_i   (rd_isr),
        .clr_i  (soft_rst),
        .isr_o  (isr_val),
        .irq_o  (irq_o)
    );

    // queue slots
    logic [31:0] q_page   [NQ];
    logic [15:0] q_size   [NQ];
    logic        q_active [NQ];
    logic [63:0] q_desc   [NQ];
    logic [63:0] q_avail  [NQ];
    logic [63:0] q_used   [NQ];

    for (genvar gi = 0; gi < NQ; gi++) begin : g_queue
        localparam int QS = 1 << (QSIZE_LOG2 - gi);
        vio_queue_slot #(
            .QSIZE     (QS),
            .PAGE_SHIFT(PAGE_SHIFT)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (wr_page && (sel_q == 16'(gi))),
            .clr_i   (soft_rst),
            .page_i  (wdata_i),
            .page_o  (q_page[gi]),
            .size_o  (q_size[gi]),
            .active_o(q_active[gi]),
            .desc_o  (q_desc[gi]),
            .avail_o (q_avail[gi]),
            .used_o  (q_used[gi])
        );
    end

    // notify forwarding
    logic [15:0]   notify_num;
    logic [QW-1:0] notify_idx;
    logic          notify_ok;

    assign notify_num = wdata_i[15:0];
    assign notify_idx = notify_num[QW-1:0];
    assign notify_ok  = wr_notify && (notify_num < NQ16) && q_active[notify_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            notify_o       <= '0;
            notify_desc_o  <= '0;
            notify_avail_o <= '0;
            notify_used_o  <= '0;
        end else begin
            notify_o <= notify_ok ? (NQ'(1) << notify_idx) : '0;
            if (notify_ok) begin
                notify_desc_o  <= q_desc[notify_idx];
                notify_avail_o <= q_avail[notify_idx];
                notify_used_o  <= q_used[notify_idx];
            end
        end
    end

    // read path
    logic [31:0] rd_mux;

    always_comb begin
        if (in_cfg)                 rd_mux = cfg_rdata_i;
        else if (addr_i == A_HOST)  rd_mux = host_rd;
        else if (addr_i == A_GUEST) rd_mux = guest_feat_o;
        else if (addr_i == A_PAGE)  rd_mux = q_page[sel_idx];
        else if (addr_i == A_QSIZE) rd_mux = {16'd0, q_size[sel_idx]};
        else if (addr_i == A_QSEL)  rd_mux = {16'd0, sel_q};
        else if (addr_i == A_STAT)  rd_mux = {24'd0, status_q};
        else if (addr_i == A_ISR)   rd_mux = 32'(isr_val);
        else                        rd_mux = 32'hFFFF_FFFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else begin
            rvalid_o <= rd;
            if (rd)
                rdata_o <= rd_mux;
        end
    end

    // lifecycle state machine
    dev_state_t state_q, state_d;
    logic       drv_ok_new;

    assign drv_ok_new = wdata_i[STATUS_DRV_OK_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (soft_rst)
            state_d = ST_RESET;
        else if (wr_status) begin
            if (drv_ok_new && !status_q[STATUS_DRV_OK_BIT])
                state_d = ST_READY;
            else if (drv_ok_new)
                state_d = ST_LIVE;
            else
                state_d = ST_SETUP;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_SETUP: state_d = ST_SETUP;
                ST_READY: state_d = ST_LIVE;
                ST_LIVE:  state_d = ST_LIVE;
                ST_RESET: state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dev_reset_o = 1'b0;
        ready_o     = 1'b0;
        unique case (state_q)
            ST_READY: ready_o     = 1'b1;
            ST_RESET: dev_reset_o = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busmaster_o <= 1'b0;
        else if (state_d == ST_READY)
            busmaster_o <= 1'b1;
    end

    // assertions
    a_r3_sel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q < NQ16);

    a_r5_notify_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(notify_o));

    a_r5_notify_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_notify |=> (notify_o == '0));

    a_r8_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    a_r8_ready_busmaster: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> busmaster_o);

    a_r9_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        dev_reset_o |-> (!irq_o && (guest_feat_o == 32'd0)));

    a_r11_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rvalid_o);
endmodule

// File: tb/vio_port_regfile_tb.sv
module vio_port_regfile_tb;
    localparam int NQ = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] wdata_i = '0;
    logic        rvalid_o;
    logic [31:0] rdata_o;
    logic [7:0]  irq_cause_i = '0;
    logic        irq_o;
    logic [31:0] guest_feat_o;
    logic        dev_reset_o, ready_o, busmaster_o;
    logic [NQ-1:0] notify_o;
    logic [63:0] notify_desc_o, notify_avail_o, notify_used_o;
    logic        cfg_req_o, cfg_we_o;
    logic [7:0]  cfg_addr_o;
    logic [1:0]  cfg_size_o;
    logic [31:0] cfg_wdata_o;
    logic [31:0] cfg_rdata_i = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vio_port_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .size_i(size_i), .wdata_i(wdata_i), .rvalid_o(rvalid_o), .rdata_o(rdata_o),
        .irq_cause_i(irq_cause_i), .irq_o(irq_o), .guest_feat_o(guest_feat_o),
        .dev_reset_o(dev_reset_o), .ready_o(ready_o), .busmaster_o(busmaster_o),
        .notify_o(notify_o), .notify_desc_o(notify_desc_o),
        .notify_avail_o(notify_avail_o), .notify_used_o(notify_used_o),
        .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_addr_o(cfg_addr_o),
        .cfg_size_o(cfg_size_o), .cfg_wdata_o(cfg_wdata_o), .cfg_rdata_i(cfg_rdata_i)
    );

    // {we, addr, size, wdata, expected read data}
    localparam int NV = 27;
    localparam logic [74:0] VEC [NV] = '{
        {1'b0, 8'h00, 2'd2, 32'h0, 32'h4100_0021},
        {1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0000},
        {1'b1, 8'h04, 2'd2, 32'h0000_0001, 32'h0},
        {1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0001},
        {1'b1, 8'h04, 2'd2, 32'h0000_0003, 32'h0},
        {1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0001},
        {1'b1, 8'h04, 2'd2, 32'h4000_0002, 32'h0},
        {1'b0, 8'h04, 2'd2, 32'h0, 32'h0000_0020},
        {1'b1, 8'h04, 2'd2, 32'h0100_0020, 32'h0},
        {1'b0, 8'h04, 2'd2, 32'h0, 32'h0100_0020},
        {1'b0, 8'h0C, 2'd1, 32'h0, 32'h0000_0100},
        {1'b1, 8'h0E, 2'd1, 32'h0000_0002, 32'h0},
        {1'b0, 8'h0E, 2'd1, 32'h0, 32'h0000_0002},
        {1'b0, 8'h0C, 2'd1, 32'h0, 32'h0000_0040},
        {1'b1, 8'h0E, 2'd1, 32'h0000_0003, 32'h0},
        {1'b0, 8'h0E, 2'd1, 32'h0, 32'h0000_0002},
        {1'b1, 8'h0E, 2'd2, 32'h0001_0001, 32'h0},
        {1'b0, 8'h0C, 2'd1, 32'h0, 32'h0000_0080},
        {1'b1, 8'h08, 2'd2, 32'h0000_0010, 32'h0},
        {1'b0, 8'h08, 2'd2, 32'h0, 32'h0000_0010},
        {1'b1, 8'h0E, 2'd1, 32'h0000_0000, 32'h0},
        {1'b0, 8'h08, 2'd2, 32'h0, 32'h0000_0000},
        {1'b0, 8'h10, 2'd1, 32'h0, 32'hFFFF_FFFF},
        {1'b0, 8'h11, 2'd0, 32'h0, 32'hFFFF_FFFF},
        {1'b1, 8'h12, 2'd0, 32'h0000_0003, 32'h0},
        {1'b0, 8'h12, 2'd0, 32'h0, 32'h0000_0003},
        {1'b0, 8'h13, 2'd0, 32'h0, 32'h0000_0000}
    };

    function automatic string vec_tag(int i);
        if (i == 0) return "R1";
        if (i < 10) return "R2";
        if (i < 18) return "R3";
        if (i < 22) return "R4";
        if (i < 24) return "R11";
        return "R8";
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(logic w, logic [7:0] a, logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        req_i = 1'b1; we_i = w; addr_i = a; size_i = s; wdata_i = d;
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
    endtask

    task automatic raise(logic [7:0] c);
        @(negedge clk);
        irq_cause_i = c;
        @(negedge clk);
        irq_cause_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R9 R11)
        chk("R9 reset irq", irq_o, 0);
        chk("R8 reset busmaster", busmaster_o, 0);
        chk("R8 reset ready", ready_o, 0);
        chk("R9 reset pulse idle", dev_reset_o, 0);
        chk("R5 reset notify", notify_o, 0);
        chk("R11 reset rvalid", rvalid_o, 0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][74], VEC[i][73:66], VEC[i][65:64], VEC[i][63:32]);
            if (!VEC[i][74]) begin
                chk({vec_tag(i), " rvalid"}, rvalid_o, 1);
                chk({vec_tag(i), " table read"}, rdata_o, VEC[i][31:0]);
            end
        end

        // R5: queue 1 has page 0x10, size 128
        access(1, 8'h10, 2'd1, 32'h0000_0001);
        chk("R5 notify q1", notify_o, 3'b010);
        chk("R5 desc", notify_desc_o, 64'h1_0000);
        chk("R5 avail", notify_avail_o, 64'h1_0800);
        chk("R5 used", notify_used_o, 64'h1_1000);
        @(negedge clk);
        chk("R5 strobe one cycle", notify_o, 0);
        access(1, 8'h10, 2'd1, 32'h0000_0000);
        chk("R5 no notify idle queue", notify_o, 0);
        access(1, 8'h10, 2'd1, 32'h0000_0005);
        chk("R5 no notify out of range", notify_o, 0);

        // R8: status is 3, now set driver ok
        access(1, 8'h12, 2'd0, 32'h0000_0007);
        chk("R8 ready pulse", ready_o, 1);
        chk("R8 busmaster", busmaster_o, 1);
        @(negedge clk);
        chk("R8 ready drops", ready_o, 0);
        access(1, 8'h12, 2'd0, 32'h0000_0007);
        chk("R8 no second ready", ready_o, 0);

        // R6 R7
        raise(8'h02);
        chk("R6 irq up", irq_o, 1);
        raise(8'h04);
        access(0, 8'h13, 2'd0, 32'h0);
        chk("R7 isr value", rdata_o, 32'h6);
        chk("R7 irq down", irq_o, 0);
        access(0, 8'h13, 2'd0, 32'h0);
        chk("R7 isr cleared", rdata_o, 32'h0);

        // R7 collision: read and raise in the same cycle
        raise(8'h02);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; addr_i = 8'h13; size_i = 2'd0; irq_cause_i = 8'h01;
        @(negedge clk);
        req_i = 1'b0; irq_cause_i = '0;
        chk("R7 collision old value", rdata_o, 32'h2);
        chk("R7 collision irq kept", irq_o, 1);
        access(0, 8'h13, 2'd0, 32'h0);
        chk("R7 collision new cause", rdata_o, 32'h1);

        // R10 config window
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b0; addr_i = 8'h20; size_i = 2'd2; cfg_rdata_i = 32'hCAFE_F00D;
        #1;
        chk("R10 cfg req", cfg_req_o, 1);
        chk("R10 cfg addr", cfg_addr_o, 8'h0C);
        @(negedge clk);
        req_i = 1'b0; cfg_rdata_i = '0;
        chk("R10 cfg rdata", rdata_o, 32'hCAFE_F00D);
        @(negedge clk);
        req_i = 1'b1; we_i = 1'b1; addr_i = 8'h14; size_i = 2'd0; wdata_i = 32'h55;
        #1;
        chk("R10 cfg write", {cfg_req_o, cfg_we_o, cfg_addr_o, cfg_size_o}, {1'b1, 1'b1, 8'h00, 2'd0});
        chk("R10 cfg wdata", cfg_wdata_o, 32'h55);
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;

        // R9 status zero with pending interrupt
        raise(8'h01);
        access(1, 8'h0E, 2'd1, 32'h1);
        access(1, 8'h12, 2'd0, 32'h0);
        chk("R9 reset pulse", dev_reset_o, 1);
        chk("R9 irq lowered", irq_o, 0);
        chk("R9 guest cleared", guest_feat_o, 0);
        access(0, 8'h0E, 2'd1, 32'h0);
        chk("R9 selector cleared", rdata_o, 0);
        chk("R9 pulse one cycle", dev_reset_o, 0);
        access(0, 8'h12, 2'd0, 32'h0);
        chk("R9 status cleared", rdata_o, 0);
        access(1, 8'h0E, 2'd1, 32'h1);
        access(0, 8'h08, 2'd2, 32'h0);
        chk("R9 page cleared", rdata_o, 0);
        chk("R9 busmaster kept", busmaster_o, 1);

        // R9 page zero write
        access(1, 8'h04, 2'd2, 32'h1);
        access(1, 8'h08, 2'd2, 32'h0);
        chk("R9 page zero pulse", dev_reset_o, 1);
        access(0, 8'h04, 2'd2, 32'h0);
        chk("R9 page zero guest", rdata_o, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule